// File: doc/BRIEF.md
# Dual-mode DAC input demultiplexer

This block is the digital front end of a two-channel DAC. Each channel holds its word in two registers in series. A capture register takes a word from a data bus, and an output register holds the code that the converter core drives. One mode input sets how four shared control pins are read. In dual-port mode each channel has its own bus, its own write strobe and its own update clock, and the two channels never affect each other. In interleaved mode a single bus carries I and Q words in turn. A select pin steers each word into channel A or channel B. An update clock, divided by two inside the block, then moves both captured words into the output registers together. A hold pin can block that clock and restart the division.

All strobes and clocks enter as plain levels and are sampled by one fast system clock. Their rising edges are found synchronously, so the whole block runs in one clock domain. Each output register raises a one-cycle update pulse when it loads. A one-cycle error pulse marks any change of the select pin made while the interleaved write strobe or update clock is high.

Top module: `dual_dac_front`

## Requirements
- R1: `mode_dual` = 1 selects dual-port mode and `mode_dual` = 0 selects interleaved mode. In dual-port mode the pins are write A (`ctl0_wr`), clock A (`ctl1_clk`), clock B (`ctl2_clk_hold`) and write B (`ctl3_wr_sel`). In interleaved mode the same pins are write, update clock, hold and select.
- R2: In dual-port mode, a rising edge on a channel's write pin loads that channel's bus into its capture register. The output code does not change at that point.
- R3: In dual-port mode, a rising edge on a channel's clock pin loads that channel's output register from its capture register, and leaves the other channel untouched. An output code changes only in a cycle where that channel's update pulse is high.
- R4: In interleaved mode `bus_b` has no effect on either output code.
- R5: In interleaved mode, a rising edge on the write pin loads `bus_a` into capture register A when the select pin is 1, and into capture register B when it is 0.
- R6: In interleaved mode, both output registers load together on the 1st, 3rd, 5th and later rising edges of the update clock, counted from the last phase clear. The edges in between cause no update.
- R7: While the hold pin is high in interleaved mode, update-clock edges cause no update. The hold also clears the divide phase, so the first update-clock edge after release loads both outputs.
- R8: Codes are straight binary and pass through unchanged, with bit DW-1 as the MSB.
- R9: In interleaved mode, a change of the select pin sampled while the write pin or the update clock is high raises `proto_err` for exactly one cycle, in the cycle after the change is sampled. A change while both are low raises nothing, and `proto_err` stays low in dual-port mode.
- R10: A synchronous `rst` clears all four registers to 0 and holds the update and error pulses low.
- R11: Each update pulse lasts one cycle. It is high in the first cycle in which the new code is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst | input | 1 | Synchronous reset, active high |
| mode_dual | input | 1 | 1 selects dual-port mode, 0 selects interleaved mode |
| bus_a | input | DW | Channel A data, or the shared interleaved data |
| bus_b | input | DW | Channel B data, used in dual-port mode only |
| ctl0_wr | input | 1 | Write A, or the interleaved write |
| ctl1_clk | input | 1 | Clock A, or the interleaved update clock |
| ctl2_clk_hold | input | 1 | Clock B, or the interleaved hold |
| ctl3_wr_sel | input | 1 | Write B, or the interleaved select |
| code_a | output | DW | Channel A output register |
| code_b | output | DW | Channel B output register |
| upd_a | output | 1 | Channel A load pulse |
| upd_b | output | 1 | Channel B load pulse |
| proto_err | output | 1 | Pulse for a select change made at a forbidden time |

## Verification
A wrong capture register stays hidden until the next update-clock edge copies it to an output code, so each sweep writes a fresh word and then clocks it out. A stale or swapped word then shows on the very next update. A wrong divide phase shows as an update on the wrong edge of a clock pair. The first edge after each hold release tells a phase that was never cleared apart from one that was cleared. A bad edge detector shows as a missing or doubled update pulse in the cycle right after the strobe.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   typedef enum logic {
      MODE_INTERLEAVED = 1'b0,
      MODE_DUAL        = 1'b1
   } dac_mode_e;

   localparam int PIN_N   = 4;
   localparam int P_WR0   = 0;
   localparam int P_CLK1  = 1;
   localparam int P_CLK2  = 2;
   localparam int P_WR3   = 3;
   localparam int CHAN_N  = 2;
endpackage

// File: rtl/dacfe_rise.sv
module dacfe_rise #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] pin,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic prev_q;
      always_ff @(posedge clk) begin
         if (rst) prev_q <= 1'b0;
         else     prev_q <= pin[i];
      end
      assign rise[i] = pin[i] & ~prev_q;
   end
endmodule

// File: rtl/dacfe_halver.sv
module dacfe_halver (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic tick,
   output logic fire
);
   logic phase_q;

   assign fire = tick & ~hold & ~phase_q;

   always_ff @(posedge clk) begin
      if (rst || hold) phase_q <= 1'b0;
      else if (tick)   phase_q <= ~phase_q;
   end
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld_in,
   input  logic [DW-1:0] din,
   input  logic          ld_dac,
   output logic [DW-1:0] code,
   output logic          upd
);
   logic [DW-1:0] cap_q;
   logic [DW-1:0] out_q;
   logic          upd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_q <= '0;
         out_q <= '0;
         upd_q <= 1'b0;
      end else begin
         if (ld_in)  cap_q <= din;
         if (ld_dac) out_q <= cap_q;
         upd_q <= ld_dac;
      end
   end

   assign code = out_q;
   assign upd  = upd_q;
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
   import dacfe_pkg::*;
#(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mode_dual,
   input  logic [DW-1:0] bus_a,
   input  logic [DW-1:0] bus_b,
   input  logic          ctl0_wr,
   input  logic          ctl1_clk,
   input  logic          ctl2_clk_hold,
   input  logic          ctl3_wr_sel,
   output logic [DW-1:0] code_a,
   output logic [DW-1:0] code_b,
   output logic          upd_a,
   output logic          upd_b,
   output logic          proto_err
);
   if (DW < 2) begin : g_bad_width
      $error("dual_dac_front: DW must be at least 2");
   end

   dac_mode_e            mode_e;
   logic [PIN_N-1:0]     pins;
   logic [PIN_N-1:0]     rise;
   logic                 fire;
   logic                 sel_q;
   logic                 err_q;
   logic [CHAN_N-1:0]    ld_in;
   logic [CHAN_N-1:0]    ld_dac;
   logic [CHAN_N-1:0]    upd_w;
   logic [CHAN_N-1:0][DW-1:0] din;
   logic [CHAN_N-1:0][DW-1:0] code_w;

   assign mode_e = dac_mode_e'(mode_dual);
   assign pins   = {ctl3_wr_sel, ctl2_clk_hold, ctl1_clk, ctl0_wr};

   dacfe_rise #(.N(PIN_N)) u_rise (
      .clk  (clk),
      .rst  (rst),
      .pin  (pins),
      .rise (rise)
   );

   dacfe_halver u_half (
      .clk  (clk),
      .rst  (rst),
      .hold (mode_dual | ctl2_clk_hold),
      .tick (rise[P_CLK1]),
      .fire (fire)
   );

   always_comb begin
      if (mode_e == MODE_DUAL) begin
         ld_in[0]  = rise[P_WR0];
         ld_in[1]  = rise[P_WR3];
         din[0]    = bus_a;
         din[1]    = bus_b;
         ld_dac[0] = rise[P_CLK1];
         ld_dac[1] = rise[P_CLK2];
      end else begin
         ld_in[0]  = rise[P_WR0] & ctl3_wr_sel;
         ld_in[1]  = rise[P_WR0] & ~ctl3_wr_sel;
         din[0]    = bus_a;
         din[1]    = bus_a;
         ld_dac[0] = fire;
         ld_dac[1] = fire;
      end
   end

   for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
      dacfe_chan #(.DW(DW)) u_chan (
         .clk    (clk),
         .rst    (rst),
         .ld_in  (ld_in[c]),
         .din    (din[c]),
         .ld_dac (ld_dac[c]),
         .code   (code_w[c]),
         .upd    (upd_w[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         sel_q <= ctl3_wr_sel;
         err_q <= (mode_e == MODE_INTERLEAVED) && (ctl3_wr_sel != sel_q)
                  && (ctl0_wr || ctl1_clk);
      end
   end

   assign code_a    = code_w[0];
   assign code_b    = code_w[1];
   assign upd_a     = upd_w[0];
   assign upd_b     = upd_w[1];
   assign proto_err = err_q;
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int DW = 10
) (
   input logic          clk,
   input logic          rst,
   input logic          mode_dual,
   input logic          ctl2_clk_hold,
   input logic [DW-1:0] code_a,
   input logic [DW-1:0] code_b,
   input logic          upd_a,
   input logic          upd_b,
   input logic          proto_err
);
   a_r6_paired_update: assert property (@(posedge clk) disable iff (rst)
      $past(!mode_dual) |-> (upd_a == upd_b));

   a_r7_hold_blocks: assert property (@(posedge clk) disable iff (rst)
      (!mode_dual && ctl2_clk_hold) |=> (!upd_a && !upd_b));

   a_r3_code_a_quiet: assert property (@(posedge clk) disable iff (rst)
      (!upd_a && !$past(rst)) |-> $stable(code_a));

   a_r3_code_b_quiet: assert property (@(posedge clk) disable iff (rst)
      (!upd_b && !$past(rst)) |-> $stable(code_b));

   a_r9_err_interleaved_only: assert property (@(posedge clk) disable iff (rst)
      proto_err |-> $past(!mode_dual));

   a_r11_upd_a_single: assert property (@(posedge clk) disable iff (rst)
      upd_a |=> !upd_a);

   a_r11_upd_b_single: assert property (@(posedge clk) disable iff (rst)
      upd_b |=> !upd_b);
endmodule

bind dual_dac_front dacfe_checker #(.DW(DW)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .mode_dual     (mode_dual),
   .ctl2_clk_hold (ctl2_clk_hold),
   .code_a        (code_a),
   .code_b        (code_b),
   .upd_a         (upd_a),
   .upd_b         (upd_b),
   .proto_err     (proto_err)
);

// File: tb/tb_dual_dac_front.sv
module tb_dual_dac_front;
   localparam int DW   = 10;
   localparam int MAXV = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode_dual = 1'b1;
   logic [DW-1:0] bus_a = '0;
   logic [DW-1:0] bus_b = '0;
   logic [3:0]    ctl = '0;
   logic [DW-1:0] code_a, code_b;
   logic          upd_a, upd_b, proto_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic seen_a, seen_b;

   always #2 clk = ~clk;

   dual_dac_front #(.DW(DW)) dut (
      .clk           (clk),
      .rst           (rst),
      .mode_dual     (mode_dual),
      .bus_a         (bus_a),
      .bus_b         (bus_b),
      .ctl0_wr       (ctl[0]),
      .ctl1_clk      (ctl[1]),
      .ctl2_clk_hold (ctl[2]),
      .ctl3_wr_sel   (ctl[3]),
      .code_a        (code_a),
      .code_b        (code_b),
      .upd_a         (upd_a),
      .upd_b         (upd_b),
      .proto_err     (proto_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one-cycle high pulse on a pin; update pulses are captured mid-way
   task automatic pulse(input int idx);
      ctl[idx] = 1'b1;
      @(negedge clk);
      seen_a = upd_a;
      seen_b = upd_b;
      ctl[idx] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int prev_a, prev_b;
      int wi, wq;
      repeat (3) @(negedge clk);
      chk("R10 reset code_a", code_a, 0);
      chk("R10 reset code_b", code_b, 0);
      chk("R10 reset upd", {upd_a, upd_b}, 0);
      chk("R10 reset err", proto_err, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1 dual-port mode: full code sweep, channel B gets the complement
      mode_dual = 1'b1;
      prev_a = 0;
      prev_b = 0;
      for (int v = 0; v <= MAXV; v++) begin
         bus_a = DW'(v);
         bus_b = DW'(MAXV - v);
         pulse(0);
         chk("R2 write leaves code_a", code_a, prev_a);
         pulse(3);
         pulse(1);
         chk("R3 clock A pulses A", seen_a, 1);
         chk("R3 clock A leaves B", seen_b, 0);
         chk("R2 code_a after clock A", code_a, v);
         chk("R3 code_b untouched", code_b, prev_b);
         chk("R8 MSB is bit DW-1", code_a[DW-1], (v >= (1 << (DW - 1))) ? 1 : 0);
         pulse(2);
         chk("R3 clock B pulses B", seen_b, 1);
         chk("R11 single pulse A", upd_a, 0);
         chk("R3 code_b after clock B", code_b, MAXV - v);
         prev_a = v;
         prev_b = MAXV - v;
      end

      // R1 interleaved mode
      mode_dual = 1'b0;
      @(negedge clk);
      pulse(2);
      for (int k = 0; k < 256; k++) begin
         wi = (k * 37 + 5) % (MAXV + 1);
         wq = (k * 91 + 300) % (MAXV + 1);
         ctl[3] = 1'b1;
         @(negedge clk);
         bus_a = DW'(wi);
         bus_b = DW'((k * 53 + 7) % (MAXV + 1));
         pulse(0);
         ctl[3] = 1'b0;
         @(negedge clk);
         bus_a = DW'(wq);
         bus_b = DW'(~wq);
         pulse(0);
         chk("R9 legal select change no err", proto_err, 0);
         pulse(1);
         chk("R6 first edge pulses A", seen_a, 1);
         chk("R6 first edge pulses B", seen_b, 1);
         chk("R5 select high to A", code_a, wi);
         chk("R5 select low to B / R4 bus_b ignored", code_b, wq);
         pulse(1);
         chk("R6 second edge no update", {seen_a, seen_b}, 0);
         chk("R6 code_a held", code_a, wi);
         chk("R6 code_b held", code_b, wq);
      end

      // R7 hold blocks updates and clears the phase
      ctl[3] = 1'b1; @(negedge clk); bus_a = DW'(111); pulse(0);
      ctl[3] = 1'b0; @(negedge clk); bus_a = DW'(222); pulse(0);
      pulse(1);
      chk("R6 fire before hold A", code_a, 111);
      chk("R6 fire before hold B", code_b, 222);
      ctl[3] = 1'b1; @(negedge clk); bus_a = DW'(333); pulse(0);
      ctl[3] = 1'b0; @(negedge clk); bus_a = DW'(444); pulse(0);
      ctl[2] = 1'b1;
      @(negedge clk);
      pulse(1);
      chk("R7 held edge no update", {seen_a, seen_b}, 0);
      pulse(1);
      chk("R7 held edge no update again", {seen_a, seen_b}, 0);
      chk("R7 code_a kept under hold", code_a, 111);
      ctl[2] = 1'b0;
      @(negedge clk);
      pulse(1);
      chk("R7 first edge after release updates", {seen_a, seen_b}, 3);
      chk("R7 code_a after release", code_a, 333);
      chk("R7 code_b after release", code_b, 444);

      // R9 select change while write high
      ctl[0] = 1'b1; @(negedge clk);
      ctl[3] = ~ctl[3]; @(negedge clk);
      chk("R9 err on change with write high", proto_err, 1);
      ctl[0] = 1'b0; @(negedge clk);
      chk("R9 err lasts one cycle", proto_err, 0);
      // R9 select change while update clock high
      ctl[1] = 1'b1; @(negedge clk);
      ctl[3] = ~ctl[3]; @(negedge clk);
      chk("R9 err on change with clock high", proto_err, 1);
      ctl[1] = 1'b0; @(negedge clk);
      chk("R9 err cleared", proto_err, 0);
      // R9 no error in dual-port mode
      mode_dual = 1'b1;
      @(negedge clk);
      ctl[0] = 1'b1; @(negedge clk);
      ctl[3] = ~ctl[3]; @(negedge clk);
      chk("R9 no err in dual mode", proto_err, 0);
      ctl[0] = 1'b0; ctl[3] = 1'b0;
      @(negedge clk);
      @(negedge clk);

      // R10 reset mid-run
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R10 mid reset code_a", code_a, 0);
      chk("R10 mid reset code_b", code_b, 0);
      rst = 1'b0;
      @(negedge clk);
      pulse(1);
      chk("R10 capture cleared by reset", code_a, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule